// File: doc/BRIEF.md
# Zero-Overhead Repeat-Loop Controller

The block watches the stream of retired instructions of a small signal-processing core. Each retirement arrives as a program counter and a pre-decoded class code. The block holds a loop-start address, a loop-end address and a repeat count. When the loop-end instruction retires while the count is nonzero, the block decrements the count. If iterations remain, it asks fetch to jump back to the loop start, so the loop costs no branch instruction.

The block also polices the rules a program must follow around a hardware loop. The count may only be set once both addresses are loaded. At least one instruction must separate the count-setting instruction from the loop body. Flow-changing, loop-control and status-load instructions are banned from the tail of an active loop, and from the whole body when the loop is three instructions or shorter. A banned instruction gives a one-cycle exception pulse and takes no effect.

The block also computes the side effects of moving the loop registers. A load from a register or from memory holds a busy flag for the load latency. A memory load returns the address register advanced by one word, a store returns it retreated by one word, and a read or store returns the register value. Every output is registered and reflects the instruction that retired on the previous clock edge.

Top module: `hw_loop_ctrl`

## Requirements
- R1: A set-count instruction (class 2) retired before both the start address (class 3 from a register, class 5 from memory) and the end address (class 4 from a register, class 6 from memory) have been loaded since reset pulses order_err. The count stays unchanged.
- R2: If the first instruction retired after an accepted set-count is at the loop-start address, gap_err pulses.
- R3: While the count is nonzero, an instruction in the last three slots of the loop (addresses end-4 to end, 2-byte instructions) pulses illegal_exc if its class is banned. Banned classes are 1 (branch, call, return, trap), 2 to 6 (loop control and loop-register loads) and 11 (status-register load).
- R4: An instruction that raises illegal_exc takes no effect. There is no redirect, the count is unchanged, and no loop register is written.
- R5: For a loop of one to three instructions, the banned-class check covers every instruction from the start address to the end address.
- R6: A retirement at the end address while the count is above one decrements the count and gives a one-cycle redirect_valid with redirect_target equal to the start address. All outputs appear one cycle after the retirement.
- R7: A retirement at the end address with the count equal to one sets the count to zero and gives no redirect.
- R8: A loop-register load (classes 3 to 6) holds busy high for LOAD_STATES (4) cycles. Reads and stores (classes 7 to 10) raise no busy.
- R9: A memory load (classes 5, 6) returns rn_next = ret_rn + 4. A store (class 7 start, class 8 end) returns rn_next = ret_rn - 4, with rd_data holding the stored register. A register read (class 9 start, class 10 end) puts that register on rd_data.
- R10: Reset clears the count to zero and every pulse output. Until a count is set, no redirect or exception occurs.
- R11: An instruction outside the protected window, or any instruction while the count is zero, raises no exception, whatever its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_class | input | 4 | Pre-decoded instruction class |
| ret_data | input | AW | Load value or new count |
| ret_rn | input | AW | Address register value for memory moves |
| redirect_valid | output | 1 | Fetch must jump to redirect_target |
| redirect_target | output | AW | Loop-start address |
| illegal_exc | output | 1 | Banned instruction inside the loop window |
| order_err | output | 1 | Count set before both addresses loaded |
| gap_err | output | 1 | Loop entered right after setting the count |
| busy | output | 1 | Loop-register load in progress |
| loop_count | output | CW | Remaining repeat count |
| rd_data | output | AW | Value of a read or stored loop register |
| rn_next | output | AW | Updated address register |

## Verification
The bench runs a four-instruction loop and a two-instruction loop. In the four-instruction loop, a branch in the first slot must pass and the same branch in the second slot must trap; a design that sizes the window wrong traps in the first slot or misses the second. In the two-instruction loop, a set-count at the loop start must trap. A design that takes effect on a trapped instruction would change the count, load a new start address, or redirect. The bench catches this because a later redirect must still target the old start. It also checks that the last pass falls through with no extra redirect, that a set-count before both loads is refused, that the loop body may not follow set-count directly, and that busy holds for exactly four cycles.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic [3:0] {
    IC_OTHER   = 4'd0,
    IC_FLOW    = 4'd1,
    IC_SETCNT  = 4'd2,
    IC_LDS_REG = 4'd3,
    IC_LDE_REG = 4'd4,
    IC_LDS_MEM = 4'd5,
    IC_LDE_MEM = 4'd6,
    IC_STS_MEM = 4'd7,
    IC_STE_MEM = 4'd8,
    IC_RDS     = 4'd9,
    IC_RDE     = 4'd10,
    IC_LDSR    = 4'd11
  } iclass_e;

  typedef enum logic [1:0] {RN_HOLD, RN_INC, RN_DEC} rn_op_e;

  function automatic logic is_banned(input iclass_e c);
    return (c == IC_FLOW) || (c == IC_SETCNT) || (c == IC_LDS_REG) ||
           (c == IC_LDE_REG) || (c == IC_LDS_MEM) || (c == IC_LDE_MEM) ||
           (c == IC_LDSR);
  endfunction
endpackage

// File: rtl/hwl_window.sv
module hwl_window #(
  parameter int AW    = 16,
  parameter int STEP  = 2,
  parameter int TAIL  = 3
) (
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] end_q,
  input  logic [AW-1:0] pc,
  input  logic          active,
  output logic          in_win
);
  localparam int SPAN = (TAIL - 1) * STEP;

  logic [AW-1:0] tail_lo;
  logic [AW-1:0] lo;

  always_comb begin
    tail_lo = (end_q >= AW'(SPAN)) ? end_q - AW'(SPAN) : '0;
    lo      = (start_q > tail_lo) ? start_q : tail_lo;
    in_win  = active && (pc >= lo) && (pc <= end_q);
  end
endmodule

// File: rtl/hwl_regs.sv
module hwl_regs
  import hwl_pkg::*;
#(
  parameter int AW          = 16,
  parameter int LOAD_STATES = 4,
  parameter int WORD_BYTES  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_start,
  input  logic          we_end,
  input  logic [AW-1:0] wdata,
  input  logic          rd_en,
  input  logic          rd_sel_end,
  input  rn_op_e        rn_op,
  input  logic [AW-1:0] rn_in,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic          both_loaded,
  output logic          busy,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] rn_next
);
  localparam int BW = $clog2(LOAD_STATES + 1);

  logic          s_ld_q, e_ld_q;
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      end_q    <= '0;
      s_ld_q   <= 1'b0;
      e_ld_q   <= 1'b0;
      busy_cnt <= '0;
      rd_data  <= '0;
      rn_next  <= '0;
    end else begin
      if (we_start) begin
        start_q <= wdata;
        s_ld_q  <= 1'b1;
      end
      if (we_end) begin
        end_q  <= wdata;
        e_ld_q <= 1'b1;
      end
      if (we_start || we_end)
        busy_cnt <= BW'(LOAD_STATES);
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;
      if (rd_en)
        rd_data <= rd_sel_end ? end_q : start_q;
      case (rn_op)
        RN_INC:  rn_next <= rn_in + AW'(WORD_BYTES);
        RN_DEC:  rn_next <= rn_in - AW'(WORD_BYTES);
        default: rn_next <= rn_next;
      endcase
    end
  end

  assign both_loaded = s_ld_q && e_ld_q;
  assign busy        = (busy_cnt != '0);

  a_r8_busy_countdown: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - 1'b1) || (busy_cnt == BW'(LOAD_STATES)));

  a_r9_post_increment: assert property (@(posedge clk) disable iff (rst)
    (rn_op == RN_INC) |=> (rn_next == $past(rn_in) + AW'(WORD_BYTES)));

  a_r9_pre_decrement: assert property (@(posedge clk) disable iff (rst)
    (rn_op == RN_DEC) |=> (rn_next == $past(rn_in) - AW'(WORD_BYTES)));
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl
  import hwl_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 8,
  parameter int STEP        = 2,
  parameter int TAIL        = 3,
  parameter int LOAD_STATES = 4,
  parameter int WORD_BYTES  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic [3:0]    ret_class,
  input  logic [AW-1:0] ret_data,
  input  logic [AW-1:0] ret_rn,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_target,
  output logic          illegal_exc,
  output logic          order_err,
  output logic          gap_err,
  output logic          busy,
  output logic [CW-1:0] loop_count,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] rn_next
);
  iclass_e       cls;
  logic [AW-1:0] start_q, end_q;
  logic          both_loaded, in_win, active;
  logic          illegal, ok, set_req, set_ok, at_end, need_gap_q;
  logic          we_start, we_end, rd_en, rd_sel_end;
  rn_op_e        rn_op;
  logic [CW-1:0] cnt_n;

  assign active = (loop_count != '0);

  hwl_window #(.AW(AW), .STEP(STEP), .TAIL(TAIL)) i_win (
    .start_q(start_q), .end_q(end_q), .pc(ret_pc), .active(active), .in_win(in_win)
  );

  always_comb begin
    cls        = iclass_e'(ret_class);
    illegal    = ret_valid && in_win && is_banned(cls);
    ok         = ret_valid && !illegal;
    set_req    = ok && (cls == IC_SETCNT);
    set_ok     = set_req && both_loaded;
    at_end     = ok && active && (ret_pc == end_q);
    we_start   = ok && ((cls == IC_LDS_REG) || (cls == IC_LDS_MEM));
    we_end     = ok && ((cls == IC_LDE_REG) || (cls == IC_LDE_MEM));
    rd_en      = ok && ((cls == IC_STS_MEM) || (cls == IC_STE_MEM) ||
                        (cls == IC_RDS) || (cls == IC_RDE));
    rd_sel_end = (cls == IC_STE_MEM) || (cls == IC_RDE);
    if (ok && ((cls == IC_LDS_MEM) || (cls == IC_LDE_MEM)))
      rn_op = RN_INC;
    else if (ok && ((cls == IC_STS_MEM) || (cls == IC_STE_MEM)))
      rn_op = RN_DEC;
    else
      rn_op = RN_HOLD;
    if (set_ok)
      cnt_n = ret_data[CW-1:0];
    else if (at_end)
      cnt_n = loop_count - 1'b1;
    else
      cnt_n = loop_count;
  end

  hwl_regs #(.AW(AW), .LOAD_STATES(LOAD_STATES), .WORD_BYTES(WORD_BYTES)) i_regs (
    .clk(clk), .rst(rst), .we_start(we_start), .we_end(we_end), .wdata(ret_data),
    .rd_en(rd_en), .rd_sel_end(rd_sel_end), .rn_op(rn_op), .rn_in(ret_rn),
    .start_q(start_q), .end_q(end_q), .both_loaded(both_loaded), .busy(busy),
    .rd_data(rd_data), .rn_next(rn_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_count      <= '0;
      need_gap_q      <= 1'b0;
      redirect_valid  <= 1'b0;
      redirect_target <= '0;
      illegal_exc     <= 1'b0;
      order_err       <= 1'b0;
      gap_err         <= 1'b0;
    end else begin
      loop_count      <= cnt_n;
      redirect_valid  <= at_end && (loop_count > CW'(1));
      redirect_target <= start_q;
      illegal_exc     <= illegal;
      order_err       <= set_req && !both_loaded;
      gap_err         <= ret_valid && need_gap_q && (ret_pc == start_q);
      if (set_ok)
        need_gap_q <= 1'b1;
      else if (ret_valid)
        need_gap_q <= 1'b0;
    end
  end

  a_r4_exc_blocks_redirect: assert property (@(posedge clk) disable iff (rst)
    illegal_exc |-> !redirect_valid);

  a_r4_exc_keeps_count: assert property (@(posedge clk) disable iff (rst)
    illegal_exc |-> (loop_count == $past(loop_count)));

  a_r1_order_keeps_count: assert property (@(posedge clk) disable iff (rst)
    order_err |-> (loop_count == $past(loop_count)));

  a_r6_redirect_decrements: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (loop_count == $past(loop_count) - CW'(1)));

  a_r6_redirect_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect_valid, illegal_exc, order_err}));
endmodule

// File: tb/test_hw_loop_ctrl.sv
module test_hw_loop_ctrl;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          ret_valid;
  logic [AW-1:0] ret_pc, ret_data, ret_rn;
  logic [3:0]    ret_class;
  logic          redirect_valid, illegal_exc, order_err, gap_err, busy;
  logic [AW-1:0] redirect_target, rd_data, rn_next;
  logic [CW-1:0] loop_count;

  hw_loop_ctrl #(.AW(AW), .CW(CW)) i_hw_loop_ctrl (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_class(ret_class), .ret_data(ret_data), .ret_rn(ret_rn),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .illegal_exc(illegal_exc), .order_err(order_err), .gap_err(gap_err),
    .busy(busy), .loop_count(loop_count), .rd_data(rd_data), .rn_next(rn_next)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic          redir;
    logic [AW-1:0] target;
    logic          exc, ord, gap, bsy;
    logic [CW-1:0] cnt;
    logic          aux;
    logic [AW-1:0] rd, rn;
    string         tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    bz       = 0;

  task automatic issue(input logic [AW-1:0] pc, input logic [3:0] cls,
                       input logic [AW-1:0] data, input logic [AW-1:0] rn,
                       input logic e_redir, input logic e_exc, input logic e_ord,
                       input logic e_gap, input logic [CW-1:0] e_cnt,
                       input logic e_aux, input logic [AW-1:0] e_rd,
                       input logic [AW-1:0] e_rn, input string tag);
    item_t it;
    @(negedge clk);
    ret_valid = 1'b1; ret_pc = pc; ret_class = cls; ret_data = data; ret_rn = rn;
    if (cls >= 4'd3 && cls <= 4'd6 && !e_exc) bz = 4;
    else if (bz > 0) bz--;
    it.redir = e_redir; it.target = 16'h0100; it.exc = e_exc; it.ord = e_ord;
    it.gap = e_gap; it.bsy = (bz != 0); it.cnt = e_cnt; it.aux = e_aux;
    it.rd = e_rd; it.rn = e_rn; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input logic [AW-1:0] pc, input logic [3:0] cls,
                     input logic [CW-1:0] cnt, input logic redir,
                     input logic exc, input string tag);
    issue(pc, cls, '0, '0, redir, exc, 1'b0, 1'b0, cnt, 1'b0, '0, '0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t e;
      logic bad;
      e = q.pop_front();
      bad = (redirect_valid !== e.redir) || (illegal_exc !== e.exc) ||
            (order_err !== e.ord) || (gap_err !== e.gap) || (busy !== e.bsy) ||
            (loop_count !== e.cnt) || (e.redir && redirect_target !== e.target) ||
            (e.aux && (rd_data !== e.rd || rn_next !== e.rn));
      n_checks++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: got redir=%0b tgt=%h exc=%0b ord=%0b gap=%0b busy=%0b cnt=%0d rd=%h rn=%h; exp redir=%0b tgt=%h exc=%0b ord=%0b gap=%0b busy=%0b cnt=%0d rd=%h rn=%h",
                 e.tag, redirect_valid, redirect_target, illegal_exc, order_err, gap_err,
                 busy, loop_count, rd_data, rn_next, e.redir, e.target, e.exc, e.ord,
                 e.gap, e.bsy, e.cnt, e.rd, e.rn);
      end
    end
  end

  initial begin
    #150000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ret_valid = 1'b0; ret_pc = '0; ret_class = '0; ret_data = '0; ret_rn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10: reset state
    n_checks++;
    if (redirect_valid || illegal_exc || order_err || gap_err || busy || loop_count != 0) begin
      n_fail++;
      $display("FAIL R10 reset: got redir=%0b exc=%0b ord=%0b gap=%0b busy=%0b cnt=%0d, expected all zero",
               redirect_valid, illegal_exc, order_err, gap_err, busy, loop_count);
    end
    // R1: count before any load refused
    issue(16'h0080, 4'd2, 16'd3, '0, 0, 0, 1, 0, 0, 0, '0, '0, "R1 no loads");
    issue(16'h0082, 4'd3, 16'h0100, '0, 0, 0, 0, 0, 0, 0, '0, '0, "R8 start load busy");
    issue(16'h0084, 4'd2, 16'd3, '0, 0, 0, 1, 0, 0, 0, '0, '0, "R1 end missing");
    // R9: memory load post-increment, store pre-decrement, read
    issue(16'h0086, 4'd6, 16'h0106, 16'h0040, 0, 0, 0, 0, 0, 1, '0, 16'h0044, "R9 load inc");
    issue(16'h0088, 4'd7, '0, 16'h0050, 0, 0, 0, 0, 0, 1, 16'h0100, 16'h004C, "R9 store dec");
    issue(16'h008A, 4'd10, '0, '0, 0, 0, 0, 0, 0, 1, 16'h0106, 16'h004C, "R9 read end");
    run(16'h008C, 4'd0, 0, 0, 0, "R8 busy tail");
    run(16'h008E, 4'd0, 0, 0, 0, "R8 busy done");
    // R10/R11: inactive loop, banned class at end is harmless
    run(16'h0106, 4'd1, 0, 0, 0, "R10 R11 inactive");
    // R6/R7: four-instruction loop, two passes
    issue(16'h00F0, 4'd2, 16'd2, '0, 0, 0, 0, 0, 2, 0, '0, '0, "R1 accepted");
    run(16'h00F2, 4'd0, 2, 0, 0, "R2 gap ok");
    run(16'h0100, 4'd0, 2, 0, 0, "R6 body");
    run(16'h0102, 4'd0, 2, 0, 0, "R6 body");
    run(16'h0104, 4'd0, 2, 0, 0, "R6 body");
    run(16'h0106, 4'd0, 1, 1, 0, "R6 redirect");
    for (int a = 16'h0100; a < 16'h0106; a += 2) run(AW'(a), 4'd0, 1, 0, 0, "R6 pass2");
    run(16'h0106, 4'd0, 0, 0, 0, "R7 fall through");
    run(16'h0108, 4'd0, 0, 0, 0, "R7 after loop");
    // R2, R3, R4, R11
    issue(16'h00F0, 4'd2, 16'd2, '0, 0, 0, 0, 0, 2, 0, '0, '0, "R1 accepted again");
    issue(16'h0100, 4'd1, '0, '0, 0, 0, 0, 1, 2, 0, '0, '0, "R2 no gap R11 outside window");
    run(16'h0102, 4'd1, 2, 0, 1, "R3 branch in window");
    issue(16'h0104, 4'd3, 16'h0200, '0, 0, 1, 0, 0, 2, 0, '0, '0, "R3 R4 start load banned");
    run(16'h0106, 4'd11, 2, 0, 1, "R4 status load at end");
    run(16'h0106, 4'd0, 1, 1, 0, "R4 start kept");
    for (int a = 16'h0100; a < 16'h0106; a += 2) run(AW'(a), 4'd0, 1, 0, 0, "R7 pass2");
    run(16'h0106, 4'd0, 0, 0, 0, "R7 end");
    // R5: two-instruction loop
    issue(16'h00E0, 4'd4, 16'h0102, '0, 0, 0, 0, 0, 0, 0, '0, '0, "R8 end load");
    issue(16'h00F0, 4'd2, 16'd3, '0, 0, 0, 0, 0, 3, 0, '0, '0, "R5 setup");
    run(16'h00F2, 4'd0, 3, 0, 0, "R5 gap");
    issue(16'h0100, 4'd2, 16'd9, '0, 0, 1, 0, 0, 3, 0, '0, '0, "R5 short loop start banned");
    run(16'h0100, 4'd0, 3, 0, 0, "R5 body");
    run(16'h0102, 4'd0, 2, 1, 0, "R6 short redirect");
    run(16'h0100, 4'd0, 2, 0, 0, "R5 body");
    run(16'h0102, 4'd0, 1, 1, 0, "R6 short redirect");
    run(16'h0100, 4'd0, 1, 0, 0, "R5 body");
    run(16'h0102, 4'd0, 0, 0, 0, "R7 short fall through");
    run(16'h0100, 4'd2, 0, 0, 0, "R11 inactive");
    @(negedge clk); ret_valid = 1'b0;
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule